// File: doc/BRIEF.md
# Serial EEPROM Target

This block is a two-wire bus target that behaves like a small serial EEPROM. It holds 2 KB, arranged as 8 blocks of 256 bytes. The master selects a block through three bits inside the 7-bit device address. The four fixed bits above them are 1010. A system clock oversamples the clock and data lines. The block pulls the data line low through an open-drain enable, and a write-protect input stops stores to the array.

A write frame goes as follows: START, the device byte with R/W = 0, one in-block address byte, then one or more data bytes, and STOP. The target acknowledges the device byte and each following byte while it stores them. Data bytes of a page write advance only the low four address bits, so a page of 16 bytes wraps onto itself. A read frame returns bytes from an 11-bit address pointer, which counts across block boundaries. A dummy write followed by a repeated START sets that pointer for a random read. The read goes on while the master acknowledges each byte, and a missing acknowledge ends it.

Top module: `eep_target`

## Requirements
- R1: Only a device byte whose upper four bits are 1010 is acknowledged. For any other device byte the target never pulls SDA low, and it ignores the bytes that follow until the next START. The array is unchanged.
- R2: The target acknowledges by holding SDA low during the ninth SCL clock. This applies to a matching device byte, to the address byte and to every data byte of a write frame.
- R3: A byte write to device byte {1010, blk, 0} at offset `ofs` stores the data at array location blk*256 + ofs.
- R4: In a write frame each data byte advances only the low 4 bits of the address. Bytes past the end of a 16-byte page wrap to its start, so a 17th byte overwrites the first byte written. Bytes outside that page are untouched.
- R5: A random read is a dummy write of block and offset, a repeated START, then device byte {1010, blk, 1}. It returns the stored byte, most significant bit first.
- R6: A sequential read increments the 11-bit pointer after each byte the master acknowledges. Offset 0xFF of block b is followed by offset 0x00 of block b+1.
- R7: When the master does not acknowledge a read byte, the target releases SDA and drives nothing more until the next START.
- R8: While wp_i is high, write frames are still acknowledged but leave the array unchanged. Reads work normally.
- R9: A START or STOP at any point, including inside a byte, clears the bit counter and returns the frame logic to the device-byte phase (START) or to idle (STOP). The partial byte is discarded.
- R10: After reset SDA is released. SDA changes only while SCL is low, except where a START or STOP releases it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Sensed level of the bus clock line |
| sda_i | input | 1 | Sensed level of the bus data line |
| wp_i | input | 1 | Write protect; high blocks every store to the array |
| sda_oe | output | 1 | Pull the data line low when 1 (open-drain enable) |

## Verification
The bench writes the 17th byte of a page and checks where it lands. It also places a guard byte just past the page: a design that carries into bit 4 would corrupt the guard, and one that drops the wrap would leave the first byte intact. A sequential read starts at the last two offsets of block 0 and must continue into block 1. A pointer limited to eight bits would instead return offset 0 of block 0. Two more frames target faults in framing and protection. One frame breaks a byte with a STOP and another with a repeated START; a design that kept the half-received bits would store garbage or misalign the next device byte. Protected writes and foreign device IDs are checked by reading back the earlier value, and a broken design would overwrite it.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_WADR,
    ST_WDAT,
    ST_RDAT
  } fr_state_e;
endpackage

// File: rtl/eep_line_sync.sv
module eep_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl,
  output logic sda,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  localparam int NL = 2;

  logic [NL-1:0] raw;
  logic [NL-1:0] synced;
  logic [NL-1:0] prev;

  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < NL; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '1;
      else     chain <= {chain[STAGES-2:0], raw[g]};
    end
    assign synced[g] = chain[STAGES-1];
  end

  always_ff @(posedge clk) begin
    if (rst) prev <= '1;
    else     prev <= synced;
  end

  assign scl       = synced[1];
  assign sda       = synced[0];
  assign scl_rise  =  synced[1] & ~prev[1];
  assign scl_fall  = ~synced[1] &  prev[1];
  assign bus_start =  synced[1] &  prev[1] &  prev[0] & ~synced[0];
  assign bus_stop  =  synced[1] &  prev[1] & ~prev[0] &  synced[0];
endmodule

// File: rtl/eep_store.sv
module eep_store #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/eep_frame.sv
module eep_frame
  import eep_pkg::*;
#(
  parameter int         BLK_W      = 3,
  parameter int         OFS_W      = 8,
  parameter int         PAGE_W     = 4,
  parameter logic [6:0] DEV_PREFIX = 7'b1010000
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   scl,
  input  logic                   sda,
  input  logic                   scl_rise,
  input  logic                   scl_fall,
  input  logic                   bus_start,
  input  logic                   bus_stop,
  input  logic                   wp,
  input  logic [7:0]             rdata,
  output logic [BLK_W+OFS_W-1:0] raddr,
  output logic [BLK_W+OFS_W-1:0] waddr,
  output logic                   we,
  output logic [7:0]             wdata,
  output logic                   sda_oe
);
  localparam int AW = BLK_W + OFS_W;

  fr_state_e        state;
  logic [3:0]       cnt;
  logic [7:0]       shreg;
  logic [7:0]       tx;
  logic [AW-1:0]    ptr;
  logic [BLK_W-1:0] blk;
  logic             mack;
  logic             id_hit;

  assign id_hit = ((shreg[7:1] >> BLK_W) == (DEV_PREFIX >> BLK_W));
  assign raddr  = ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      shreg  <= '0;
      tx     <= '0;
      ptr    <= '0;
      blk    <= '0;
      mack   <= 1'b1;
      we     <= 1'b0;
      wdata  <= '0;
      waddr  <= '0;
      sda_oe <= 1'b0;
    end else begin
      we <= 1'b0;
      if (bus_stop) begin
        state  <= ST_IDLE;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (bus_start) begin
        state  <= ST_DEV;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (state != ST_IDLE) begin
        if (scl_rise) begin
          if (cnt < 4'd8)  shreg <= {shreg[6:0], sda};
          if (cnt == 4'd8) mack  <= sda;
          if (cnt < 4'd9)  cnt   <= cnt + 4'd1;
        end else if (scl_fall) begin
          if (cnt == 4'd8) begin
            case (state)
              ST_DEV: begin
                if (id_hit) begin
                  sda_oe <= 1'b1;
                  blk    <= shreg[BLK_W:1];
                  if (shreg[0]) begin
                    state             <= ST_RDAT;
                    ptr[AW-1:OFS_W]   <= shreg[BLK_W:1];
                  end else begin
                    state <= ST_WADR;
                  end
                end else begin
                  state <= ST_IDLE;
                end
              end
              ST_WADR: begin
                sda_oe <= 1'b1;
                ptr    <= {blk, shreg[OFS_W-1:0]};
                state  <= ST_WDAT;
              end
              ST_WDAT: begin
                sda_oe               <= 1'b1;
                we                   <= ~wp;
                wdata                <= shreg;
                waddr                <= ptr;
                ptr[PAGE_W-1:0]      <= ptr[PAGE_W-1:0] + 1'b1;
              end
              ST_RDAT: sda_oe <= 1'b0;
              default: sda_oe <= 1'b0;
            endcase
          end else if (cnt == 4'd9) begin
            cnt <= '0;
            if (state == ST_RDAT) begin
              if (!mack) begin
                tx     <= rdata;
                sda_oe <= ~rdata[7];
                ptr    <= ptr + 1'b1;
              end else begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
              end
            end else begin
              sda_oe <= 1'b0;
            end
          end else if (cnt != 4'd0 && state == ST_RDAT) begin
            sda_oe <= ~tx[6];
            tx     <= {tx[6:0], 1'b0};
          end
        end
      end
    end
  end

  // R9: a bus condition leaves the bit counter cleared
  a_r9_event_clears_count: assert property (@(posedge clk) disable iff (rst)
    (bus_start || bus_stop) |=> (cnt == 4'd0));

  // R10: SDA holds still through a high SCL phase unless a bus condition occurred
  a_r10_sda_steady_scl_high: assert property (@(posedge clk) disable iff (rst)
    (scl && $past(scl) && !$past(bus_start) && !$past(bus_stop)) |-> $stable(sda_oe));

  // R2: outside a read, SDA is pulled only in the acknowledge slot
  a_r2_pull_only_in_slot: assert property (@(posedge clk) disable iff (rst)
    (sda_oe && state != ST_RDAT) |-> (cnt >= 4'd8));

  // R4: a store never leaves the page the pointer is in
  a_r4_store_inside_page: assert property (@(posedge clk) disable iff (rst)
    we |-> (waddr[AW-1:PAGE_W] == ptr[AW-1:PAGE_W]));

  a_r4_page_bits_held: assert property (@(posedge clk) disable iff (rst)
    we |-> (ptr[AW-1:PAGE_W] == $past(ptr[AW-1:PAGE_W])));

  // R9: the counter never runs past the acknowledge clock
  a_r9_count_range: assert property (@(posedge clk) disable iff (rst)
    cnt <= 4'd9);
endmodule

// File: rtl/eep_target.sv
module eep_target #(
  parameter int         BLK_W      = 3,
  parameter int         OFS_W      = 8,
  parameter int         PAGE_W     = 4,
  parameter int         SYNC_STG   = 2,
  parameter logic [6:0] DEV_PREFIX = 7'b1010000
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  input  logic wp_i,
  output logic sda_oe
);
  localparam int AW = BLK_W + OFS_W;

  logic          scl_s, sda_s, scl_rise, scl_fall, ev_start, ev_stop;
  logic          mem_we;
  logic [AW-1:0] mem_waddr, mem_raddr;
  logic [7:0]    mem_wdata, mem_rdata;

  eep_line_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl       (scl_s),
    .sda       (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .bus_start (ev_start),
    .bus_stop  (ev_stop)
  );

  eep_frame #(
    .BLK_W      (BLK_W),
    .OFS_W      (OFS_W),
    .PAGE_W     (PAGE_W),
    .DEV_PREFIX (DEV_PREFIX)
  ) u_frame (
    .clk       (clk),
    .rst       (rst),
    .scl       (scl_s),
    .sda       (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .bus_start (ev_start),
    .bus_stop  (ev_stop),
    .wp        (wp_i),
    .rdata     (mem_rdata),
    .raddr     (mem_raddr),
    .waddr     (mem_waddr),
    .we        (mem_we),
    .wdata     (mem_wdata),
    .sda_oe    (sda_oe)
  );

  eep_store #(.AW(AW), .DW(8)) u_store (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (mem_raddr),
    .rdata (mem_rdata)
  );

  // R8: a steady protect level lets no store reach the array
  a_r8_protect_blocks_store: assert property (@(posedge clk) disable iff (rst)
    (wp_i && $past(wp_i)) |-> !mem_we);
endmodule

// File: tb/tb_eep_target.sv
module tb_eep_target;
  localparam int Q = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_low = 1'b0;
  logic wp = 1'b0;
  logic sda_oe_w;
  wire  sda_line = ~(sda_low | sda_oe_w);

  int n_tests = 0;
  int n_fail  = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] obs;
  event       ev_obs;

  always #2 clk = ~clk;

  eep_target dut (
    .clk    (clk),
    .rst    (rst),
    .scl_i  (scl_m),
    .sda_i  (sda_line),
    .wp_i   (wp),
    .sda_oe (sda_oe_w)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_low = 1'b0; hold(Q);
    scl_m = 1'b1;   hold(Q);
    sda_low = 1'b1; hold(Q);
    scl_m = 1'b0;   hold(Q);
  endtask

  task automatic bus_stop();
    sda_low = 1'b1; hold(Q);
    scl_m = 1'b1;   hold(Q);
    sda_low = 1'b0; hold(Q);
  endtask

  task automatic send_bit(input logic b);
    sda_low = ~b; hold(Q);
    scl_m = 1'b1; hold(2*Q);
    scl_m = 1'b0; hold(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_low = 1'b0; hold(Q);
    scl_m = 1'b1;   hold(Q);
    acked = (sda_line == 1'b0);
    hold(Q);
    scl_m = 1'b0;   hold(Q);
  endtask

  task automatic recv_byte(input bit m_ack);
    logic [7:0] b;
    for (int i = 7; i >= 0; i--) begin
      sda_low = 1'b0; hold(Q);
      scl_m = 1'b1;   hold(Q);
      b[i] = sda_line;
      hold(Q);
      scl_m = 1'b0;   hold(Q);
    end
    sda_low = m_ack; hold(Q);
    scl_m = 1'b1;    hold(2*Q);
    scl_m = 1'b0;    hold(Q);
    sda_low = 1'b0;
    obs = b;
    -> ev_obs;
    hold(1);
  endtask

  task automatic send_acked(input logic [7:0] b, input string req);
    bit a;
    send_byte(b, a);
    check(a, req, a, 1);
  endtask

  task automatic wr_frame(input logic [2:0] blk, input logic [7:0] ofs,
                          input logic [7:0] data[$], input string req);
    bus_start();
    send_acked({4'b1010, blk, 1'b0}, "R2 device byte ack");
    send_acked(ofs, "R2 address byte ack");
    foreach (data[i]) send_acked(data[i], req);
    bus_stop();
  endtask

  task automatic rd_frame(input logic [2:0] blk, input logic [7:0] ofs,
                          input logic [7:0] expd[$], input string req);
    bus_start();
    send_acked({4'b1010, blk, 1'b0}, "R5 dummy write ack");
    send_acked(ofs, "R5 read offset ack");
    bus_start();
    send_acked({4'b1010, blk, 1'b1}, "R5 read device ack");
    foreach (expd[i]) begin
      exp_q.push_back(expd[i]);
      tag_q.push_back(req);
      recv_byte(i != expd.size() - 1);
    end
    check(sda_oe_w == 1'b0, "R7 released after nack", sda_oe_w, 0);
    bus_stop();
    check(sda_oe_w == 1'b0, "R7 released after stop", sda_oe_w, 0);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(ev_obs);
      if (exp_q.size() == 0) begin
        check(1'b0, "unexpected read byte", obs, 0);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(obs === e, t, obs, e);
      end
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d[$];
    logic [7:0] e[$];
    bit a;
    hold(8);
    rst = 1'b0;
    hold(4);
    check(sda_oe_w == 1'b0, "R10 released after reset", sda_oe_w, 0);

    // R3: byte write then random read back
    d = '{8'hA5};
    wr_frame(3'd2, 8'h34, d, "R3 data ack");
    e = '{8'hA5};
    rd_frame(3'd2, 8'h34, e, "R5 random read of byte write R3");

    // R1: foreign IDs are not acknowledged, following bytes ignored
    bus_start();
    send_byte(8'h94, a); check(!a, "R1 foreign id 1001 nack", a, 0);
    send_byte(8'h34, a); check(!a, "R1 following byte ignored", a, 0);
    send_byte(8'h11, a); check(!a, "R1 data byte ignored", a, 0);
    bus_stop();
    bus_start();
    send_byte(8'hB4, a); check(!a, "R1 foreign id 1011 nack", a, 0);
    send_byte(8'h34, a);
    send_byte(8'h22, a);
    bus_stop();
    e = '{8'hA5};
    rd_frame(3'd2, 8'h34, e, "R1 array unchanged");

    // R4: guard byte after the page, then 17-byte page write from offset 6
    d = '{8'h77};
    wr_frame(3'd1, 8'h20, d, "R3 guard ack");
    d = {};
    for (int i = 0; i < 17; i++) d.push_back(8'h40 + i[7:0]);
    wr_frame(3'd1, 8'h16, d, "R2 page data ack");
    e = {};
    for (int k = 0; k < 16; k++) begin
      if (k == 6) e.push_back(8'h50);
      else        e.push_back(8'h40 + ((k[7:0] - 8'd6) & 8'h0F));
    end
    e.push_back(8'h77);
    rd_frame(3'd1, 8'h10, e, "R4 page wrap and guard");

    // R6: sequential read across block 0 -> block 1
    d = '{8'h11, 8'h22};
    wr_frame(3'd0, 8'hFE, d, "R3 tail ack");
    d = '{8'h33, 8'h44};
    wr_frame(3'd1, 8'h00, d, "R3 head ack");
    e = '{8'h11, 8'h22, 8'h33, 8'h44};
    rd_frame(3'd0, 8'hFE, e, "R6 cross-block sequential");

    // R8: protected write acknowledged but not stored; read under protect
    wp = 1'b1;
    hold(4);
    d = '{8'h5A};
    wr_frame(3'd2, 8'h34, d, "R8 protected data ack");
    e = '{8'hA5};
    rd_frame(3'd2, 8'h34, e, "R8 protected read unchanged");
    wp = 1'b0;
    hold(4);

    // R9: STOP inside a data byte discards it
    d = '{8'h01};
    wr_frame(3'd3, 8'h00, d, "R3 setup ack");
    bus_start();
    send_acked(8'hA6, "R9 device ack");
    send_acked(8'h00, "R9 offset ack");
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    bus_stop();
    e = '{8'h01};
    rd_frame(3'd3, 8'h00, e, "R9 stop mid byte discards");

    // R9: repeated START inside a byte realigns to a new device byte
    bus_start();
    send_acked(8'hA6, "R9 device ack second");
    send_acked(8'h00, "R9 offset ack second");
    for (int i = 0; i < 3; i++) send_bit(1'b0);
    bus_start();
    send_acked(8'hA7, "R9 read device after restart");
    exp_q.push_back(8'h01);
    tag_q.push_back("R9 restart mid byte read");
    recv_byte(1'b0);
    bus_stop();
    check(sda_oe_w == 1'b0, "R10 idle after frames", sda_oe_w, 0);

    hold(20);
    check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule